// File: doc/BRIEF.md
# Per-Bit Security and Privilege Register Access Filter

This block stands between a simple single-cycle register bus and a bank of power-control registers. Every access carries two qualifier bits: secure and privileged. The filter keeps two configuration registers. The first holds one security bit per item group. The second holds two privilege controls: one for secure-configured items and one for non-secure-configured items. A chip-level security-enable input also takes part. From these it builds, in the same cycle as the access, a per-bit mask that decides which bits of the addressed register may be written and which may be read.

Bits that an access may not reach are not reported as errors. The bus never signals an error. On a write, such bits keep their old value, and on a read they return zero. A small example register bank stands in for the real power-control registers. A constant map assigns each of its bits to an item group.

Top module: `secflt_top`

## Requirements
- R1: After a synchronous active-high reset, the security register, both privilege bits and every bank register are 0. Reads of every address then return 0.
- R2: The address map is: 0 is the security register, 1 is the privilege register, and 2 to NBANK+1 are bank registers 0 to NBANK-1. Other addresses read 0 and ignore writes. Read data is valid combinationally in the cycle of the access and is 0 when no read is selected. Writes take effect at the next clock edge.
- R3: Bit b of bank register r belongs to item group (r + b / (DW/NITEMS)) mod NITEMS. Such a bit is secure when the security-enable input is 1 and the security register bit of its group is 1. A non-secure write leaves a secure bit unchanged, and a non-secure read returns 0 for it.
- R4: While the security-enable input is 0, the security register reads 0 and ignores all writes, and every bank bit is treated as non-secure.
- R5: The security register, held in bits NITEMS-1:0, is written only by a secure access. While the secure-privilege bit is 1, the write must also be privileged.
- R6: The privilege register is readable by every access, with the secure-privilege bit at bit 0 and the non-secure-privilege bit at bit 1. Bit 0 is written only by a secure privileged access. Bit 1 is written by any privileged access. Unprivileged writes to this register are ignored.
- R7: While the secure-privilege bit is 1, secure bank bits are readable and writable only by secure privileged accesses. The security and privilege registers remain readable by unprivileged accesses.
- R8: While the non-secure-privilege bit is 1, non-secure bank bits are readable and writable only by privileged accesses. The exception is the OPEN_RD_MASK bits of the last bank register (default bits 1:0 at address NBANK+1): these stay readable by unprivileged accesses, though writing them still needs privilege.
- R9: Secure accesses reach non-secure bank bits under the same privilege rule as non-secure accesses.
- R10: Filtering acts per bit. One access may write or read some bits of a register while others are masked, and it always completes without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tz_en | input | 1 | Chip-level security enable |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_sec | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | DW | Filtered read data, same cycle |

## Verification
Two things can meet in one cycle: a write to a configuration register, and a change of the security-enable input in the same cycle. The same goes for a configuration write that is directly followed by a bank access, which must already see the new masks. The bench flips the security-enable input at random between back-to-back accesses and mixes configuration writes densely into bank traffic. Its model judges each access against the configuration and enable values of that exact cycle, and applies writes only after the edge.

// File: rtl/secflt_pkg.sv
package secflt_pkg;

    typedef enum logic [1:0] {
        AREA_SEC  = 2'd0,
        AREA_PRIV = 2'd1,
        AREA_BANK = 2'd2,
        AREA_NONE = 2'd3
    } area_e;

    typedef struct packed {
        logic nspriv;
        logic spriv;
    } privcfg_t;

    // Item group of bit b in bank register r.
    function automatic int item_of(int r, int b, int dw, int nitems);
        return (r + b / (dw / nitems)) % nitems;
    endfunction

endpackage

// File: rtl/secflt_cfg.sv
module secflt_cfg
    import secflt_pkg::*;
#(
    parameter int NITEMS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tz_en,
    input  logic              wr_sec_reg,
    input  logic              wr_priv_reg,
    input  logic              acc_sec,
    input  logic              acc_priv,
    input  logic [NITEMS-1:0] sec_wdata,
    input  logic [1:0]        priv_wdata,
    output logic [NITEMS-1:0] seccfg,
    output privcfg_t          pcfg
);

    logic sec_wr_ok;
    assign sec_wr_ok = tz_en && acc_sec && (acc_priv || !pcfg.spriv);

    always_ff @(posedge clk) begin
        if (rst) begin
            seccfg <= '0;
            pcfg   <= '0;
        end else begin
            if (wr_sec_reg && sec_wr_ok)
                seccfg <= sec_wdata;
            if (wr_priv_reg && acc_priv) begin
                pcfg.nspriv <= priv_wdata[1];
                if (acc_sec)
                    pcfg.spriv <= priv_wdata[0];
            end
        end
    end

    // R6
    spriv_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_priv_reg && acc_sec && acc_priv) |=> $stable(pcfg.spriv));

    // R6
    nspriv_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_priv_reg && acc_priv) |=> $stable(pcfg.nspriv));

    // R4
    seccfg_tzoff_chk: assert property (@(posedge clk) disable iff (rst)
        !tz_en |=> $stable(seccfg));

    // R5
    seccfg_ns_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_sec |=> $stable(seccfg));

endmodule

// File: rtl/secflt_policy.sv
module secflt_policy
    import secflt_pkg::*;
#(
    parameter int          DW           = 16,
    parameter int          NITEMS       = 4,
    parameter int          NBANK        = 4,
    parameter int unsigned OPEN_RD_MASK = 32'h0003,
    localparam int         IDX_W        = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              tz_en,
    input  logic [NITEMS-1:0] seccfg,
    input  privcfg_t          pcfg,
    input  logic [IDX_W-1:0]  bank_idx,
    input  logic              acc_wr,
    input  logic              acc_sec,
    input  logic              acc_priv,
    output logic [DW-1:0]     mask
);

    logic [NBANK-1:0][DW-1:0] grp_sec;

    for (genvar r = 0; r < NBANK; r++) begin : g_reg
        for (genvar b = 0; b < DW; b++) begin : g_bit
            localparam int ITM = item_of(r, b, DW, NITEMS);
            assign grp_sec[r][b] = seccfg[ITM];
        end
    end

    logic [DW-1:0] sec_bits;
    logic [DW-1:0] open_rd;
    logic [DW-1:0] ns_ok;
    logic          sec_ok;

    always_comb begin
        sec_bits = tz_en ? grp_sec[bank_idx] : '0;
        open_rd  = (!acc_wr && bank_idx == IDX_W'(NBANK - 1)) ? DW'(OPEN_RD_MASK) : '0;
        sec_ok   = acc_sec && (acc_priv || !pcfg.spriv);
        ns_ok    = {DW{acc_priv || !pcfg.nspriv}} | open_rd;
        mask     = (sec_bits & {DW{sec_ok}}) | (~sec_bits & ns_ok);
    end

endmodule

// File: rtl/secflt_bank.sv
module secflt_bank #(
    parameter int  DW    = 16,
    parameter int  NBANK = 4,
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DW-1:0]            wmask,
    input  logic [DW-1:0]            wdata,
    output logic [NBANK-1:0][DW-1:0] regs
);

    for (genvar r = 0; r < NBANK; r++) begin : g_r
        always_ff @(posedge clk) begin
            if (rst)
                regs[r] <= '0;
            else if (we && idx == IDX_W'(r))
                regs[r] <= (regs[r] & ~wmask) | (wdata & wmask);
        end
    end

    // R10
    bank_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs));

endmodule

// File: rtl/secflt_top.sv
module secflt_top
    import secflt_pkg::*;
#(
    parameter int          DW           = 16,
    parameter int          NITEMS       = 4,
    parameter int          NBANK        = 4,
    parameter int unsigned OPEN_RD_MASK = 32'h0003,
    parameter int          AW           = $clog2(NBANK + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tz_en,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_sec,
    input  logic          bus_priv,
    output logic [DW-1:0] bus_rdata
);

    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    area_e                    area;
    logic [IDX_W-1:0]         bank_idx;
    logic [NITEMS-1:0]        seccfg;
    privcfg_t                 pcfg;
    logic [DW-1:0]            mask;
    logic [NBANK-1:0][DW-1:0] bank_q;

    always_comb begin
        area = AREA_NONE;
        if (bus_addr == AW'(0))
            area = AREA_SEC;
        else if (bus_addr == AW'(1))
            area = AREA_PRIV;
        else if ({1'b0, bus_addr} < (AW + 1)'(NBANK + 2))
            area = AREA_BANK;
    end

    assign bank_idx = IDX_W'(bus_addr - AW'(2));

    secflt_cfg #(.NITEMS(NITEMS)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .tz_en       (tz_en),
        .wr_sec_reg  (bus_sel && bus_wr && area == AREA_SEC),
        .wr_priv_reg (bus_sel && bus_wr && area == AREA_PRIV),
        .acc_sec     (bus_sec),
        .acc_priv    (bus_priv),
        .sec_wdata   (bus_wdata[NITEMS-1:0]),
        .priv_wdata  (bus_wdata[1:0]),
        .seccfg      (seccfg),
        .pcfg        (pcfg)
    );

    secflt_policy #(
        .DW(DW), .NITEMS(NITEMS), .NBANK(NBANK), .OPEN_RD_MASK(OPEN_RD_MASK)
    ) u_pol (
        .tz_en    (tz_en),
        .seccfg   (seccfg),
        .pcfg     (pcfg),
        .bank_idx (bank_idx),
        .acc_wr   (bus_wr),
        .acc_sec  (bus_sec),
        .acc_priv (bus_priv),
        .mask     (mask)
    );

    secflt_bank #(.DW(DW), .NBANK(NBANK)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_sel && bus_wr && area == AREA_BANK),
        .idx   (bank_idx),
        .wmask (mask),
        .wdata (bus_wdata),
        .regs  (bank_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (area)
                AREA_SEC:  if (tz_en) bus_rdata[NITEMS-1:0] = seccfg;
                AREA_PRIV: bus_rdata[1:0] = {pcfg.nspriv, pcfg.spriv};
                AREA_BANK: bus_rdata = bank_q[bank_idx] & mask;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R4
    tzoff_seccfg_raz_chk: assert property (@(posedge clk) disable iff (rst)
        bus_sel && !bus_wr && area == AREA_SEC && !tz_en |-> bus_rdata == '0);

    // R3
    ns_read_secure_raz_chk: assert property (@(posedge clk) disable iff (rst)
        bus_sel && !bus_wr && !bus_sec && tz_en && (&seccfg) && area == AREA_BANK
        |-> bus_rdata == '0);

    // R8
    nspriv_write_block_chk: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_wr && !bus_priv && pcfg.nspriv && !tz_en && area == AREA_BANK
        |=> $stable(bank_q));

    // R2
    write_no_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> bus_rdata == '0);

endmodule

// File: tb/sim_secflt_top.sv
module sim_secflt_top;
    localparam int DW     = 16;
    localparam int NITEMS = 4;
    localparam int NBANK  = 4;
    localparam int AW     = 3;
    localparam logic [DW-1:0] OPEN = 16'h0003;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, tz_en, sel, wr, sec, priv;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;

    secflt_top #(.DW(DW), .NITEMS(NITEMS), .NBANK(NBANK), .OPEN_RD_MASK(32'h0003)) u0 (
        .clk(clk), .rst(rst), .tz_en(tz_en), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_sec(sec), .bus_priv(priv),
        .bus_rdata(rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [NITEMS-1:0] m_sec;
    logic              m_sp, m_nsp;
    logic [DW-1:0]     m_bank [NBANK];

    function automatic int item(int r, int b);
        return (r + b / (DW / NITEMS)) % NITEMS;
    endfunction

    function automatic logic [DW-1:0] allow(int r, bit w, bit s, bit p);
        logic [DW-1:0] a;
        for (int b = 0; b < DW; b++) begin
            if (tz_en && m_sec[item(r, b)])
                a[b] = s && (p || !m_sp);
            else
                a[b] = p || !m_nsp || (!w && r == NBANK - 1 && OPEN[b]);
        end
        return a;
    endfunction

    function automatic logic [DW-1:0] exp_read(int a, bit s, bit p);
        logic [DW-1:0] v = '0;
        if (a == 0) begin
            if (tz_en) v[NITEMS-1:0] = m_sec;
        end else if (a == 1) begin
            v[1:0] = {m_nsp, m_sp};
        end else if (a < NBANK + 2) begin
            v = m_bank[a-2] & allow(a - 2, 1'b0, s, p);
        end
        return v;
    endfunction

    function automatic string tag_for(int a);
        if (a == 0) return "R5";
        if (a == 1) return "R6";
        if (a < NBANK + 2) return "R3";
        return "R2";
    endfunction

    task automatic model_write(int a, bit s, bit p, logic [DW-1:0] d);
        logic [DW-1:0] m;
        if (a == 0) begin
            if (tz_en && s && (p || !m_sp)) m_sec = d[NITEMS-1:0];
        end else if (a == 1) begin
            if (p) begin
                if (s) m_sp = d[0];
                m_nsp = d[1];
            end
        end else if (a < NBANK + 2) begin
            m = allow(a - 2, 1'b1, s, p);
            m_bank[a-2] = (m_bank[a-2] & ~m) | (d & m);
        end
    endtask

    task automatic model_reset();
        m_sec = '0; m_sp = 1'b0; m_nsp = 1'b0;
        for (int r = 0; r < NBANK; r++) m_bank[r] = '0;
    endtask

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(string req, bit t, int a, bit w, bit s, bit p, logic [DW-1:0] d);
        @(negedge clk);
        tz_en = t; sel = 1'b1; wr = w; addr = AW'(a); sec = s; priv = p; wdata = d;
        #1;
        if (w) check(req, rdata, '0);
        else   check(req, rdata, exp_read(a, s, p));
        if (w) model_write(a, s, p, d);
    endtask

    initial begin
        void'($urandom(32'd24681));
        rst = 1'b1; tz_en = 1'b1; sel = 1'b0; wr = 1'b0; addr = '0;
        sec = 1'b0; priv = 1'b0; wdata = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, unprivileged non-secure reads
        for (int a = 0; a < 8; a++) acc("R1", 1'b1, a, 1'b0, 1'b0, 1'b0, '0);
        // R10: open register, full write and read back
        acc("R10", 1'b1, 2, 1'b1, 1'b0, 1'b0, 16'hFFFF);
        acc("R10", 1'b1, 2, 1'b0, 1'b0, 1'b0, '0);
        // R5: non-secure write ignored, secure write lands
        acc("R5", 1'b1, 0, 1'b1, 1'b0, 1'b1, 16'h000F);
        acc("R5", 1'b1, 0, 1'b0, 1'b0, 1'b0, '0);
        acc("R5", 1'b1, 0, 1'b1, 1'b1, 1'b0, 16'h0001);
        // R3 / R10: item 0 secure, bits 3:0 of bank 0 hidden
        acc("R3", 1'b1, 2, 1'b0, 1'b0, 1'b1, '0);
        acc("R3", 1'b1, 2, 1'b1, 1'b0, 1'b1, 16'h0000);
        acc("R10", 1'b1, 2, 1'b0, 1'b1, 1'b0, '0);
        // R6: privilege register write rules
        acc("R6", 1'b1, 1, 1'b1, 1'b1, 1'b0, 16'h0003);
        acc("R6", 1'b1, 1, 1'b0, 1'b0, 1'b0, '0);
        acc("R6", 1'b1, 1, 1'b1, 1'b0, 1'b1, 16'h0003);
        acc("R6", 1'b1, 1, 1'b0, 1'b0, 1'b0, '0);
        acc("R6", 1'b1, 1, 1'b1, 1'b1, 1'b1, 16'h0003);
        acc("R6", 1'b1, 1, 1'b0, 1'b0, 1'b0, '0);
        // R7: secure unprivileged blocked; config still readable
        acc("R7", 1'b1, 2, 1'b0, 1'b1, 1'b0, '0);
        acc("R7", 1'b1, 2, 1'b1, 1'b1, 1'b0, 16'h1234);
        acc("R7", 1'b1, 0, 1'b1, 1'b1, 1'b0, 16'h000F);
        acc("R7", 1'b1, 0, 1'b0, 1'b0, 1'b0, '0);
        acc("R7", 1'b1, 1, 1'b0, 1'b1, 1'b0, '0);
        // R8: last bank register, open bits 1:0
        acc("R8", 1'b1, NBANK + 1, 1'b1, 1'b1, 1'b1, 16'hFFFF);
        acc("R8", 1'b1, NBANK + 1, 1'b0, 1'b0, 1'b0, '0);
        acc("R8", 1'b1, NBANK + 1, 1'b1, 1'b0, 1'b0, 16'h0000);
        acc("R8", 1'b1, NBANK + 1, 1'b0, 1'b1, 1'b1, '0);
        // R9: secure privileged reaches everything
        acc("R9", 1'b1, 3, 1'b1, 1'b1, 1'b1, 16'hA5A5);
        acc("R9", 1'b1, 3, 1'b0, 1'b1, 1'b1, '0);
        // R4: security disabled
        acc("R4", 1'b0, 0, 1'b0, 1'b1, 1'b1, '0);
        acc("R4", 1'b0, 0, 1'b1, 1'b1, 1'b1, 16'h0000);
        acc("R4", 1'b0, 2, 1'b0, 1'b0, 1'b1, '0);
        acc("R4", 1'b1, 0, 1'b0, 1'b0, 1'b0, '0);
        // R2: unmapped addresses
        acc("R2", 1'b1, 7, 1'b1, 1'b1, 1'b1, 16'hFFFF);
        acc("R2", 1'b1, 7, 1'b0, 1'b1, 1'b1, '0);

        // random mix, enable flips between back-to-back accesses
        for (int i = 0; i < 3000; i++) begin
            bit t;
            int a;
            t = tz_en;
            if ($urandom % 20 == 0) t = ~tz_en;
            a = $urandom % 8;
            acc(tag_for(a), t, a, 1'($urandom), 1'($urandom), 1'($urandom), DW'($urandom));
        end

        // R1: reset in the middle of activity
        @(negedge clk);
        sel = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        for (int a = 0; a < 8; a++) acc("R1", 1'b1, a, 1'b0, 1'b1, 1'b1, '0);

        @(negedge clk);
        sel = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule